// File: doc/BRIEF.md
# Programmable Pattern-Match Array

This block is a small programmable logic array. It holds a set of stored words, each made of a value vector and a care mask. It compares one input vector against every stored word at the same time and produces one output bit per word. A mode input picks how a word is compared with the input. In array format only the 1-bits of the value take part. In plane format every bit whose care bit is set must equal the input. A second mode input reduces the per-bit results with AND, OR, NAND or NOR.

Words are rewritten at run time through a single write port that is sampled on the rising clock edge. The outputs follow the new contents without any other action. A build-time parameter selects the output timing. The output is either combinational or captured in a register on each clock edge.

Top module: `pla_match_array`

## Requirements
- R1: Output bit `match_o[k]` reports word k. Input bit `in_i[i]` is compared with bit i of every stored value, with the MSB written leftmost.
- R2: With `fmt_i`=0 (array) and `op_i`=0 (AND), word k matches when every 1-bit of its value is also 1 in the input. Extra 1s in the input are allowed. For words 11001100, 00110011 and 00001111, inputs 11001100, 00110011, 00001111, 10101010, 01010101 and 11000000 give 3'b001, 3'b010, 3'b100, 0, 0 and 0.
- R3: With `fmt_i`=1 (plane), each value bit whose care bit is 1 must equal the input bit. Bits whose care bit is 0 are ignored. A word with value 00110000 and care 11110000 matches input 00110101 and does not match 01110000.
- R4: With `op_i`=1 (OR), a word matches when at least one significant bit equals its input bit. The significant bits are the value 1-bits in array format and the care-1 bits in plane format.
- R5: `op_i`=2 (NAND) and `op_i`=3 (NOR) give the per-word complement of the AND and OR results.
- R6: A word with no significant bits gives 1 under AND and 0 under OR.
- R7: Several output bits can be 1 at once. With the R2 words, input 00111111 gives 3'b110 in array AND and 3'b000 in plane AND with all care bits set.
- R8: When `wr_en_i` is 1 at a rising edge, `wr_val_i` and `wr_care_i` are stored in word `wr_idx_i` and all other words keep their contents. Outputs reflect the new contents from the following cycle.
- R9: In array format the care mask has no effect on the result.
- R10: With SYNC_OUT=1, `match_o` is the result for the inputs and contents present at the previous rising edge. With SYNC_OUT=0, it follows the inputs combinationally.
- R11: While `rst_n` is low, all values and care masks are zero and the registered output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 1 | 0 = array format, 1 = plane format |
| op_i | input | 2 | 0 AND, 1 OR, 2 NAND, 3 NOR |
| in_i | input | WIDTH | Vector compared against all words |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | IDX_W | Word index to write |
| wr_val_i | input | WIDTH | Value to store |
| wr_care_i | input | WIDTH | Care mask to store (1 = significant in plane format) |
| match_o | output | WORDS | One result bit per word |

## Verification
The hardest case to reach from the ports is a full plane-format AND match on randomly written words. Every cared bit must then agree at once, and uniform random inputs almost never do this. The random phase therefore often builds the input from a stored word. It copies that word's cared bits and randomises only its don't-care bits. A second instance with combinational output runs next to the registered one. The one-cycle lag is checked both at a moment where the two instances must differ and on every cycle against the model.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic {
    FMT_ARRAY = 1'b0,
    FMT_PLANE = 1'b1
  } pla_fmt_e;

  typedef enum logic [1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_NAND = 2'd2,
    OP_NOR  = 2'd3
  } pla_op_e;
endpackage

// File: rtl/pla_pattern_store.sv
module pla_pattern_store #(
  parameter int WIDTH = 8,
  parameter int WORDS = 3,
  parameter int IDX_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [WIDTH-1:0]             wr_val_i,
  input  logic [WIDTH-1:0]             wr_care_i,
  output logic [WORDS-1:0][WIDTH-1:0]  val_o,
  output logic [WORDS-1:0][WIDTH-1:0]  care_o
);
  logic [WORDS-1:0][WIDTH-1:0] val_q, val_d;
  logic [WORDS-1:0][WIDTH-1:0] care_q, care_d;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    localparam logic [IDX_W-1:0] KIDX = IDX_W'(k);
    logic we;

    always_comb begin
      we        = wr_en_i && (wr_idx_i == KIDX);
      val_d[k]  = val_q[k];
      care_d[k] = care_q[k];
      if (we) begin
        val_d[k]  = wr_val_i;
        care_d[k] = wr_care_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q[k]  <= '0;
        care_q[k] <= '0;
      end else if (we) begin
        val_q[k]  <= val_d[k];
        care_q[k] <= care_d[k];
      end
    end
  end

  assign val_o  = val_q;
  assign care_o = care_q;

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> (int'(wr_idx_i) < WORDS));

  // R8
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (val_q[$past(wr_idx_i)] == $past(wr_val_i)) &&
                (care_q[$past(wr_idx_i)] == $past(wr_care_i)));

  // R8
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(val_q) && $stable(care_q)));
endmodule

// File: rtl/pla_word_cmp.sv
module pla_word_cmp
  import pla_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pla_fmt_e         fmt_i,
  input  pla_op_e          op_i,
  input  logic [WIDTH-1:0] in_i,
  input  logic [WIDTH-1:0] val_i,
  input  logic [WIDTH-1:0] care_i,
  output logic             hit_o
);
  logic [WIDTH-1:0] sig;
  logic [WIDTH-1:0] eq;
  logic             all_m;
  logic             any_m;

  always_comb begin
    sig   = (fmt_i == FMT_PLANE) ? care_i : val_i;
    eq    = ~(val_i ^ in_i);
    all_m = &(~sig | eq);
    any_m = |(sig & eq);
    unique case (op_i)
      OP_AND:  hit_o = all_m;
      OP_OR:   hit_o = any_m;
      OP_NAND: hit_o = ~all_m;
      OP_NOR:  hit_o = ~any_m;
      default: hit_o = 1'b0;
    endcase
  end

  // R4
  and_implies_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sig != '0) && all_m) |-> any_m);

  // R6
  empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig == '0) |-> (all_m && !any_m));
endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage #(
  parameter int WORDS    = 3,
  parameter bit SYNC_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WORDS-1:0] match_d_i,
  output logic [WORDS-1:0] match_o
);
  if (SYNC_OUT) begin : g_sync
    logic [WORDS-1:0] match_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= '0;
      else        match_q <= match_d_i;
    end

    assign match_o = match_q;

    // R10
    sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (match_o == $past(match_d_i)));
  end else begin : g_async
    assign match_o = match_d_i;
  end
endmodule

// File: rtl/pla_match_array.sv
module pla_match_array
  import pla_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int WORDS    = 3,
  parameter bit SYNC_OUT = 1'b1,
  localparam int IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] in_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_val_i,
  input  logic [WIDTH-1:0] wr_care_i,
  output logic [WORDS-1:0] match_o
);
  logic [WORDS-1:0][WIDTH-1:0] val_w;
  logic [WORDS-1:0][WIDTH-1:0] care_w;
  logic [WORDS-1:0]            match_d;
  pla_fmt_e                    fmt_e;
  pla_op_e                     op_e;

  assign fmt_e = pla_fmt_e'(fmt_i);
  assign op_e  = pla_op_e'(op_i);

  pla_pattern_store #(
    .WIDTH (WIDTH),
    .WORDS (WORDS),
    .IDX_W (IDX_W)
  ) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_val_i  (wr_val_i),
    .wr_care_i (wr_care_i),
    .val_o     (val_w),
    .care_o    (care_w)
  );

  for (genvar k = 0; k < WORDS; k++) begin : g_cmp
    pla_word_cmp #(
      .WIDTH (WIDTH)
    ) cmp_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .fmt_i  (fmt_e),
      .op_i   (op_e),
      .in_i   (in_i),
      .val_i  (val_w[k]),
      .care_i (care_w[k]),
      .hit_o  (match_d[k])
    );
  end

  pla_out_stage #(
    .WORDS    (WORDS),
    .SYNC_OUT (SYNC_OUT)
  ) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_d_i (match_d),
    .match_o   (match_o)
  );
endmodule

// File: tb/pla_match_array_tb.sv
module pla_match_array_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fmt_r = 1'b0;
  logic [1:0] op_r = 2'd0;
  logic [7:0] in_r = 8'h00;
  logic       wr_en_r = 1'b0;
  logic [1:0] wr_idx_r = 2'd0;
  logic [7:0] wr_val_r = 8'h00;
  logic [7:0] wr_care_r = 8'h00;
  logic [2:0] y_s, y_a;

  logic [7:0] m_val [3];
  logic [7:0] m_care [3];
  logic [2:0] exp_s;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pla_match_array #(.WIDTH(8), .WORDS(3), .SYNC_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_r), .op_i(op_r), .in_i(in_r),
    .wr_en_i(wr_en_r), .wr_idx_i(wr_idx_r), .wr_val_i(wr_val_r),
    .wr_care_i(wr_care_r), .match_o(y_s));

  pla_match_array #(.WIDTH(8), .WORDS(3), .SYNC_OUT(1'b0)) dut_a_i (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_r), .op_i(op_r), .in_i(in_r),
    .wr_en_i(wr_en_r), .wr_idx_i(wr_idx_r), .wr_val_i(wr_val_r),
    .wr_care_i(wr_care_r), .match_o(y_a));

  function automatic logic [2:0] ref_match(input logic f, input logic [1:0] o,
                                           input logic [7:0] x);
    logic [2:0] r;
    for (int w = 0; w < 3; w++) begin
      int nsig = 0;
      int nhit = 0;
      logic res;
      for (int b = 0; b < 8; b++) begin
        if (f ? m_care[w][b] : m_val[w][b]) begin
          nsig++;
          if (m_val[w][b] == x[b]) nhit++;
        end
      end
      res = o[0] ? (nhit > 0) : (nhit == nsig);
      r[w] = o[1] ? ~res : res;
    end
    return r;
  endfunction

  task automatic cmp(input logic [2:0] got, input logic [2:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    if (!rst_n) begin
      exp_s = 3'b000;
      for (int w = 0; w < 3; w++) begin m_val[w] = 8'h00; m_care[w] = 8'h00; end
    end else begin
      exp_s = ref_match(fmt_r, op_r, in_r);
      if (wr_en_r) begin
        m_val[wr_idx_r]  = wr_val_r;
        m_care[wr_idx_r] = wr_care_r;
      end
    end
    @(negedge clk);
    cmp(y_s, exp_s, {tag, " sync"});
    cmp(y_a, ref_match(fmt_r, op_r, in_r), {tag, " async"});
  endtask

  task automatic do_write(input logic [1:0] idx, input logic [7:0] v, input logic [7:0] c);
    wr_en_r = 1'b1; wr_idx_r = idx; wr_val_r = v; wr_care_r = c;
    step("R8 write");
    wr_en_r = 1'b0;
  endtask

  task automatic check_vec(input logic f, input logic [1:0] o, input logic [7:0] x,
                           input logic [2:0] exp, input string tag);
    fmt_r = f; op_r = o; in_r = x;
    step(tag);
    cmp(y_s, exp, {tag, " fixed sync"});
    cmp(y_a, exp, {tag, " fixed async"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 3; w++) begin m_val[w] = 8'h00; m_care[w] = 8'h00; end
    step("R11 reset");
    step("R11 reset");
    // R11: registered output cleared, cleared words give 1 under array AND
    cmp(y_s, 3'b000, "R11 reset sync out");
    cmp(y_a, 3'b111, "R11 reset empty words");
    rst_n = 1'b1;

    do_write(2'd0, 8'b11001100, 8'hFF);
    do_write(2'd1, 8'b00110011, 8'hFF);
    do_write(2'd2, 8'b00001111, 8'hFF);

    check_vec(1'b0, 2'd0, 8'b11001100, 3'b001, "R2 R1");
    check_vec(1'b0, 2'd0, 8'b00110011, 3'b010, "R2");
    check_vec(1'b0, 2'd0, 8'b00001111, 3'b100, "R2");
    check_vec(1'b0, 2'd0, 8'b10101010, 3'b000, "R2");
    check_vec(1'b0, 2'd0, 8'b01010101, 3'b000, "R2");
    check_vec(1'b0, 2'd0, 8'b11000000, 3'b000, "R2");
    check_vec(1'b0, 2'd0, 8'b00111111, 3'b110, "R7 array");
    check_vec(1'b1, 2'd0, 8'b00111111, 3'b000, "R7 plane");
    check_vec(1'b1, 2'd0, 8'b11001100, 3'b001, "R3 full care");
    check_vec(1'b0, 2'd1, 8'b10000000, 3'b001, "R4 array or");
    check_vec(1'b1, 2'd1, 8'b11001100, 3'b101, "R4 plane or");
    check_vec(1'b0, 2'd2, 8'b11001100, 3'b110, "R5 nand");
    check_vec(1'b0, 2'd3, 8'b10000000, 3'b110, "R5 nor");

    do_write(2'd2, 8'h00, 8'h00);
    check_vec(1'b0, 2'd0, 8'h00, 3'b100, "R6 and");
    check_vec(1'b0, 2'd1, 8'hFF, 3'b011, "R6 or");
    check_vec(1'b1, 2'd0, 8'h5A, 3'b100, "R6 plane and");

    do_write(2'd0, 8'b11001100, 8'h00);
    check_vec(1'b0, 2'd0, 8'b11001100, 3'b101, "R9 care ignored");

    do_write(2'd0, 8'b00110000, 8'b11110000);
    check_vec(1'b1, 2'd0, 8'b00110101, 3'b101, "R3 dont care hit");
    check_vec(1'b1, 2'd0, 8'b01110000, 3'b100, "R3 dont care miss");

    do_write(2'd1, 8'b00001111, 8'hFF);
    check_vec(1'b0, 2'd0, 8'b00001111, 3'b110, "R8 rewrite");

    // R10: combinational instance follows at once, registered one holds
    in_r = 8'h00;
    #1;
    cmp(y_a, 3'b100, "R10 async follows");
    cmp(y_s, 3'b110, "R10 sync holds");
    step("R10");

    for (int n = 0; n < 3000; n++) begin
      int j;
      fmt_r = 1'($urandom);
      op_r  = 2'($urandom);
      wr_en_r = (($urandom % 8) == 0);
      wr_idx_r = 2'($urandom % 3);
      wr_val_r = 8'($urandom);
      wr_care_r = 8'($urandom);
      j = $urandom % 3;
      if ($urandom % 2)
        in_r = (m_val[j] & (fmt_r ? m_care[j] : m_val[j])) |
               (8'($urandom) & ~(fmt_r ? m_care[j] : 8'h00));
      else
        in_r = 8'($urandom);
      step("R10 random");
    end
    wr_en_r = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule